// File: doc/BRIEF.md
# Modulo Post-Modify Address Unit

This block produces memory addresses for a datapath that walks through buffers in local memory. It keeps a small bank of pointer registers and a bank of modulus registers. On an access cycle the selected pointer appears on the address output and, at the clock edge that closes the cycle, that pointer is rewritten according to one of four step rules. The rules are step up by one, step down by one, and a circular version of each that wraps against a separately selected modulus register. The circular rules let a filter loop sweep a ring buffer of any length up to the memory size without software fix-ups.

The registers are written through one shared data input, with a separate enable and index for the pointer bank and for the modulus bank. The address output is combinational from the pointer bank and the pointer select. When no access is strobed, the pointer select still shows that pointer on the address output, so the pointer contents can be observed. Default sizing is two 8-bit pointers and two 8-bit moduli, which covers a 256-word memory.

Top module: `modpm_agu`

## Requirements
- R1: After reset every pointer and every modulus register holds 0, so `addr_o` reads 0 for either pointer select.
- R2: `addr_o` always equals the current value of the pointer chosen by `ptr_sel` (0 = first pointer, 1 = second). During an access it shows the value from before the step, and the stepped value appears only after the clock edge.
- R3: Mode code 0 (step up): the accessed pointer becomes its value plus one, and 255 becomes 0.
- R4: Mode code 1 (step down): the accessed pointer becomes its value minus one, and 0 becomes 255.
- R5: Mode code 2 (circular up), with a nonzero modulus N chosen by `mod_sel`: the pointer becomes 0 when its value plus one is at least N, and its value plus one otherwise.
- R6: Mode code 3 (circular down), with a nonzero modulus N chosen by `mod_sel`: a pointer at 0 becomes N-1, and any other value becomes the value minus one.
- R7: In modes 2 and 3 a modulus of 0 turns off wrapping, so the step is the same as in mode 0 or mode 1.
- R8: When a pointer load and an access hit the same pointer in one cycle, the pointer takes the loaded value.
- R9: A pointer changes only when it is loaded or is the pointer selected by a strobed access. A pointer load to one pointer and an access to the other pointer both take effect in the same cycle.
- R10: A modulus load writes `ld_data` into the modulus chosen by `mod_ld_idx` at the clock edge. An access in the same cycle still wraps against the old modulus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_ld_en | input | 1 | Write `ld_data` into a pointer |
| ptr_ld_idx | input | 1 | Pointer to write |
| mod_ld_en | input | 1 | Write `ld_data` into a modulus |
| mod_ld_idx | input | 1 | Modulus to write |
| ld_data | input | 8 | Shared load value |
| acc_en | input | 1 | Access strobe: step the selected pointer |
| ptr_sel | input | 1 | Pointer driven on `addr_o` and stepped by an access |
| mod_sel | input | 1 | Modulus used by the circular modes |
| mode | input | 2 | Step rule: 0 up, 1 down, 2 circular up, 3 circular down |
| addr_o | output | 8 | Memory address (selected pointer) |

## Verification
The bench targets the wrap points. These are 255 to 0 and 0 to 255 in the plain modes, the N-1 to 0 and 0 to N-1 edges in the circular modes, and a pointer that already sits above N. A design that compared against N-1 incorrectly, or wrapped on a zero modulus, would give 0 or 255 where the next count is expected. It also checks that the modulus register is chosen by `mod_sel` and not by `ptr_sel`. A mix-up there would make the pointer wrap against the wrong length. A same-cycle load and access of one pointer, and a modulus load during a circular access, would show the stepped value or the new modulus if the priority or timing were wrong.

// File: rtl/modpm_pkg.sv
package modpm_pkg;
    typedef enum logic [1:0] {
        PM_UP        = 2'd0,
        PM_DOWN      = 2'd1,
        PM_UP_RING   = 2'd2,
        PM_DOWN_RING = 2'd3
    } pm_mode_e;
endpackage

// File: rtl/modpm_step.sv
module modpm_step
    import modpm_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] lim,
    input  pm_mode_e      mode,
    output logic [AW-1:0] nxt
);
    logic [AW:0] up_w;
    logic        ring_on;

    always_comb begin
        up_w    = {1'b0, cur} + 1'b1;
        ring_on = (lim != '0);
        unique case (mode)
            PM_UP:        nxt = up_w[AW-1:0];
            PM_DOWN:      nxt = cur - 1'b1;
            PM_UP_RING:   nxt = (ring_on && (up_w >= {1'b0, lim})) ? '0 : up_w[AW-1:0];
            PM_DOWN_RING: nxt = (ring_on && (cur == '0)) ? (lim - 1'b1) : (cur - 1'b1);
            default:      nxt = cur;
        endcase
    end
endmodule

// File: rtl/modpm_limit_bank.sv
module modpm_limit_bank #(
    parameter int AW    = 8,
    parameter int DEPTH = 2,
    localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SW-1:0]            wr_idx,
    input  logic [AW-1:0]            wr_val,
    output logic [DEPTH-1:0][AW-1:0] lim_q
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_lim
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lim_q[i] <= '0;
            end else if (wr_en && (wr_idx == SW'(i))) begin
                lim_q[i] <= wr_val;
            end
        end

        // R10: a written modulus holds the load value one cycle later
        assert_lim_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx == SW'(i))) |=> (lim_q[i] == $past(wr_val)));
    end
endmodule

// File: rtl/modpm_ptr_bank.sv
module modpm_ptr_bank #(
    parameter int AW    = 8,
    parameter int DEPTH = 2,
    localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_en,
    input  logic [SW-1:0]            ld_idx,
    input  logic [AW-1:0]            ld_val,
    input  logic                     upd_en,
    input  logic [SW-1:0]            upd_idx,
    input  logic [AW-1:0]            upd_val,
    output logic [DEPTH-1:0][AW-1:0] ptr_q
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ptr
        logic hit_ld;
        logic hit_upd;
        assign hit_ld  = ld_en  && (ld_idx  == SW'(i));
        assign hit_upd = upd_en && (upd_idx == SW'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[i] <= '0;
            end else if (hit_ld) begin
                ptr_q[i] <= ld_val;
            end else if (hit_upd) begin
                ptr_q[i] <= upd_val;
            end
        end

        // R8: a load beats a simultaneous step of the same pointer
        assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_en && (ld_idx == SW'(i))) |=> (ptr_q[i] == $past(ld_val)));

        // R9: untouched pointers keep their value
        assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!(ld_en && (ld_idx == SW'(i))) && !(upd_en && (upd_idx == SW'(i))))
            |=> $stable(ptr_q[i]));
    end
endmodule

// File: rtl/modpm_agu.sv
module modpm_agu
    import modpm_pkg::*;
#(
    parameter int AW   = 8,
    parameter int NPTR = 2,
    parameter int NMOD = 2,
    localparam int PSW = (NPTR > 1) ? $clog2(NPTR) : 1,
    localparam int MSW = (NMOD > 1) ? $clog2(NMOD) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ptr_ld_en,
    input  logic [PSW-1:0] ptr_ld_idx,
    input  logic           mod_ld_en,
    input  logic [MSW-1:0] mod_ld_idx,
    input  logic [AW-1:0]  ld_data,
    input  logic           acc_en,
    input  logic [PSW-1:0] ptr_sel,
    input  logic [MSW-1:0] mod_sel,
    input  logic [1:0]     mode,
    output logic [AW-1:0]  addr_o
);
    logic [NPTR-1:0][AW-1:0] ptr_q;
    logic [NMOD-1:0][AW-1:0] lim_q;
    logic [AW-1:0]           cur_lim;
    logic [AW-1:0]           step_val;
    pm_mode_e                mode_e;
    logic                    same_ld;

    assign mode_e  = pm_mode_e'(mode);
    assign addr_o  = ptr_q[ptr_sel];
    assign cur_lim = lim_q[mod_sel];
    assign same_ld = ptr_ld_en && (ptr_ld_idx == ptr_sel);

    modpm_limit_bank #(.AW(AW), .DEPTH(NMOD)) u_lim (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mod_ld_en),
        .wr_idx (mod_ld_idx),
        .wr_val (ld_data),
        .lim_q  (lim_q)
    );

    modpm_step #(.AW(AW)) u_step (
        .cur  (addr_o),
        .lim  (cur_lim),
        .mode (mode_e),
        .nxt  (step_val)
    );

    modpm_ptr_bank #(.AW(AW), .DEPTH(NPTR)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ptr_ld_en),
        .ld_idx  (ptr_ld_idx),
        .ld_val  (ld_data),
        .upd_en  (acc_en),
        .upd_idx (ptr_sel),
        .upd_val (step_val),
        .ptr_q   (ptr_q)
    );

    // R3: plain up-step lands one above the address just issued
    assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && (mode == 2'd0) && !same_ld)
        |=> (ptr_q[$past(ptr_sel)] == AW'($past(addr_o) + 1'b1)));

    // R5: a pointer inside the ring stays inside the ring
    assert_ring_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && (mode == 2'd2) && (cur_lim != '0) && (addr_o < cur_lim) && !same_ld)
        |=> (ptr_q[$past(ptr_sel)] < $past(cur_lim)));

    // R6: circular down-step from zero lands on the top of the ring
    assert_ring_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && (mode == 2'd3) && (cur_lim != '0) && (addr_o == '0) && !same_ld)
        |=> (ptr_q[$past(ptr_sel)] == AW'($past(cur_lim) - 1'b1)));
endmodule

// File: tb/modpm_agu_test.sv
`timescale 1ns/1ps
module modpm_agu_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ptr_ld_en, ptr_ld_idx, mod_ld_en, mod_ld_idx, acc_en, ptr_sel, mod_sel;
    logic [7:0] ld_data;
    logic [1:0] mode;
    logic [7:0] addr_o;

    int  rp [2];
    int  rn [2];
    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    modpm_agu uut (
        .clk(clk), .rst_n(rst_n), .ptr_ld_en(ptr_ld_en), .ptr_ld_idx(ptr_ld_idx),
        .mod_ld_en(mod_ld_en), .mod_ld_idx(mod_ld_idx), .ld_data(ld_data),
        .acc_en(acc_en), .ptr_sel(ptr_sel), .mod_sel(mod_sel), .mode(mode), .addr_o(addr_o)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int ref_next(int p, int n, int m);
        case (m)
            0: return (p + 1) % 256;
            1: return (p + 255) % 256;
            2: return (n == 0) ? (p + 1) % 256 : ((p + 1 >= n) ? 0 : p + 1);
            default: return (n == 0) ? (p + 255) % 256 : ((p == 0) ? n - 1 : p - 1);
        endcase
    endfunction

    task automatic cyc(string tag, bit pl, int pli, bit ml, int mli, int d,
                       bit a, int ps, int ms, int md);
        int nx;
        @(negedge clk);
        ptr_ld_en = pl; ptr_ld_idx = pli[0]; mod_ld_en = ml; mod_ld_idx = mli[0];
        ld_data = d[7:0]; acc_en = a; ptr_sel = ps[0]; mod_sel = ms[0]; mode = md[1:0];
        #1;
        chk(tag, addr_o, rp[ps]);
        nx = ref_next(rp[ps], rn[ms], md);
        @(posedge clk);
        if (a)  rp[ps]  = nx;
        if (pl) rp[pli] = d;
        if (ml) rn[mli] = d;
    endtask

    task automatic peek(string tag, int idx, int exp);
        @(negedge clk);
        ptr_ld_en = 0; mod_ld_en = 0; acc_en = 0; ptr_sel = idx[0];
        #1;
        chk(tag, addr_o, exp);
        @(posedge clk);
    endtask

    task automatic ldp(int idx, int v); cyc("R2 load", 1, idx, 0, 0, v, 0, idx, 0, 0); endtask
    task automatic ldm(int idx, int v); cyc("R10 load", 0, 0, 1, idx, v, 0, 0, idx, 0); endtask
    task automatic acc(string tag, int ps, int ms, int md); cyc(tag, 0, 0, 0, 0, 0, 1, ps, ms, md); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ptr_ld_en = 0; ptr_ld_idx = 0; mod_ld_en = 0; mod_ld_idx = 0;
        ld_data = 0; acc_en = 0; ptr_sel = 0; mod_sel = 0; mode = 0;
        rp[0] = 0; rp[1] = 0; rn[0] = 0; rn[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        peek("R1 ptr0", 0, 0);
        peek("R1 ptr1", 1, 0);
        acc("R2", 0, 0, 3);
        peek("R7 zero modulus down", 0, 255);

        ldp(0, 5);
        peek("R2 loaded", 0, 5);
        acc("R2 pre-step address", 0, 0, 0);
        peek("R3 up", 0, 6);

        ldp(1, 255);
        acc("R2", 1, 0, 0);
        peek("R3 wrap 255", 1, 0);
        acc("R2", 1, 0, 1);
        peek("R4 wrap 0", 1, 255);
        acc("R2", 1, 0, 1);
        peek("R4 down", 1, 254);

        ldm(0, 4);
        ldm(1, 7);
        ldp(0, 2);
        acc("R2", 0, 0, 2);
        peek("R5 ring up", 0, 3);
        acc("R2", 0, 0, 2);
        peek("R5 ring wrap", 0, 0);
        acc("R2", 0, 0, 2);
        peek("R5 ring after wrap", 0, 1);

        ldp(1, 0);
        acc("R2", 1, 1, 3);
        peek("R6 ring down wrap", 1, 6);
        acc("R2", 1, 1, 3);
        peek("R6 ring down", 1, 5);

        ldp(0, 3);
        acc("R2", 0, 1, 2);
        peek("R5 modulus select", 0, 4);
        ldp(0, 10);
        acc("R2", 0, 0, 2);
        peek("R5 above modulus", 0, 0);

        ldm(0, 0);
        ldp(0, 255);
        acc("R2", 0, 0, 2);
        peek("R7 zero modulus up", 0, 0);
        acc("R2", 0, 0, 3);
        peek("R7 zero modulus down", 0, 255);

        cyc("R8 load and step", 1, 0, 0, 0, 9, 1, 0, 0, 0);
        peek("R8 load wins", 0, 9);
        cyc("R9 cross", 1, 1, 0, 0, 20, 1, 0, 0, 0);
        peek("R9 stepped other", 0, 10);
        peek("R9 loaded other", 1, 20);
        acc("R2", 0, 0, 0);
        peek("R9 unselected hold", 1, 20);
        cyc("R9 no strobe", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        peek("R9 no strobe hold", 0, 11);

        ldm(0, 4);
        ldp(0, 2);
        cyc("R10 load during step", 0, 0, 1, 0, 3, 1, 0, 0, 2);
        peek("R10 old modulus used", 0, 3);
        acc("R2", 0, 0, 2);
        peek("R10 new modulus used", 0, 0);

        for (int k = 0; k < 600; k++) begin
            int r;
            r = int'($urandom);
            cyc("R2 random", (r % 7) == 0, (r >> 3) & 1, (r % 11) == 0, (r >> 4) & 1,
                (r % 5 == 0) ? ((r >> 8) & 7) : ((r >> 8) & 255),
                (r >> 5) & 1, (r >> 6) & 1, (r >> 7) & 1, (r >> 16) & 3);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule